// File: doc/BRIEF.md
# SD Host Interrupt and Status Unit

This unit keeps the interrupt-facing state of an SD host controller. It holds these registers: a raw event register, an interrupt mask, a card status word, a DMA completion status register, a DMA control word and the global control word. It drives one level-sensitive interrupt line. The command sequencer and the data path report events as single-cycle set pulses on a 32-bit vector. The card-detect logic reports insertion and removal as single-cycle pulses. The DMA engine reports transmit-done and receive-done pulses. Software reaches every register through a word-addressed register port. Writes take effect at the clock edge. Reads are combinational from the current address.

Software clears raw events by writing ones to either of two addresses: the raw view or the masked view. The interrupt line is the OR of the masked events, and it is gated by an enable bit in the global control word. The global control word also carries three reset-request bits. These bits are never stored. Each one is turned into a single-cycle pulse toward the FIFO logic, the DMA logic or the whole controller, and the reset itself is done elsewhere.

Word addresses used by this unit: 0 global control, 1 interrupt mask, 2 masked events, 3 raw events, 4 card status, 5 DMA control, 6 DMA status. Other addresses read as zero, and writes to them change nothing.

Top module: `sdh_irq_status_unit`

## Requirements
- R1: After reset, global control reads 0x0000_0300, card status reads 0x0000_0100, and the mask, raw events, masked events, DMA control and DMA status all read zero, with irq_o low.
- R2: The masked-events word (address 2) reads as raw events AND mask.
- R3: irq_o is high exactly when global control bit 4 is set and the masked events are non-zero. irq_o follows any register write from the cycle after that write's clock edge.
- R4: Writing a word to address 2 or to address 3 clears every raw event bit that is one in the written word. Other bits are kept.
- R5: A one on ev_set_i sets that raw bit at the next edge, except bits 30 and 31, which are ignored there. When a hardware set and a software clear hit the same bit in the same cycle, the bit ends up set.
- R6: An insertion pulse sets raw bit 30, clears raw bit 31 and sets card status bit 8. A removal pulse clears raw bit 30, sets raw bit 31 and clears card status bit 8. If both pulses arrive in one cycle, the removal applies. Raw bits 30 and 31 are never both set.
- R7: Writing ones to card status (address 4) clears those bits. A same-cycle insertion keeps bit 8 set.
- R8: In DMA status, a transmit-done pulse sets bit 0 and bit 8 (summary), and a receive-done pulse sets bit 1 and bit 8. A write clears only those bits within bits 9..0 that are written as one. Bits above bit 9 in the written word have no effect.
- R9: Global control bits 0 (soft reset), 1 (FIFO reset) and 2 (DMA reset) always read as zero. Writing one to any of them raises soft_rst_o, fifo_rst_o or dma_rst_o respectively for exactly the one cycle after the write edge.
- R10: The interrupt mask (address 1) and DMA control (address 5) store the whole written word and read it back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr_i | input | AW (6) | Word address of the register access |
| reg_wr_i | input | 1 | Write strobe, one write per cycle |
| reg_wdata_i | input | DW (32) | Write data |
| reg_rdata_o | output | DW (32) | Read data for reg_addr_i, combinational |
| ev_set_i | input | DW (32) | Raw event set pulses from sequencer and data path |
| card_ins_i | input | 1 | Card insertion pulse |
| card_rem_i | input | 1 | Card removal pulse |
| dma_tx_done_i | input | 1 | DMA transmit completion pulse |
| dma_rx_done_i | input | 1 | DMA receive completion pulse |
| irq_o | output | 1 | Level interrupt |
| soft_rst_o | output | 1 | Controller reset request pulse |
| fifo_rst_o | output | 1 | FIFO reset request pulse |
| dma_rst_o | output | 1 | DMA reset request pulse |

## Verification
The assertions check these properties on every cycle:
- the interrupt is never high while the enable bit is clear, and never high without a masked event behind it;
- the two card bits are never set together;
- an insertion pulse always leaves the card present;
- a hardware set always survives into the next cycle;
- a transmit-done pulse always sets its flag together with the summary flag;
- a soft-reset pulse only ever follows a control write carrying that bit.

Only the bench's scenarios show the remaining behaviours: the exact values after reset, clearing through both event addresses, the removal-over-insertion priority, the 10-bit limit on DMA status clears, and the one-cycle width of the reset pulses.

// File: rtl/sdh_irq_pkg.sv
`timescale 1ns/1ps
package sdh_irq_pkg;

  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  // word addresses
  localparam int unsigned OFS_CTRL    = 0;
  localparam int unsigned OFS_MASK    = 1;
  localparam int unsigned OFS_PEND    = 2;
  localparam int unsigned OFS_RAW     = 3;
  localparam int unsigned OFS_CARD    = 4;
  localparam int unsigned OFS_DMACTL  = 5;
  localparam int unsigned OFS_DMASTAT = 6;

  typedef enum logic [2:0] {
    SEL_CTRL, SEL_MASK, SEL_PEND, SEL_RAW,
    SEL_CARD, SEL_DMACTL, SEL_DMASTAT, SEL_NONE
  } reg_sel_e;

  // field positions decoded by neighbouring logic
  localparam int BIT_INT_EN    = 4;
  localparam int N_RST_REQ     = 3;
  localparam int BIT_CARD_IN   = 30;
  localparam int BIT_CARD_OUT  = 31;
  localparam int BIT_PRESENT   = 8;
  localparam int BIT_DMA_TX    = 0;
  localparam int BIT_DMA_RX    = 1;
  localparam int BIT_DMA_SUM   = 8;
  localparam int DMA_CLR_W     = 10;

  localparam word_t CTRL_RST_VAL = 32'h0000_0300;
  localparam logic  PRESENT_RST  = 1'b1;
  localparam word_t CARD_MASK    = (word_t'(1) << BIT_CARD_IN) | (word_t'(1) << BIT_CARD_OUT);

  function automatic reg_sel_e f_decode(input logic [7:0] a);
    case (a)
      8'(OFS_CTRL):    f_decode = SEL_CTRL;
      8'(OFS_MASK):    f_decode = SEL_MASK;
      8'(OFS_PEND):    f_decode = SEL_PEND;
      8'(OFS_RAW):     f_decode = SEL_RAW;
      8'(OFS_CARD):    f_decode = SEL_CARD;
      8'(OFS_DMACTL):  f_decode = SEL_DMACTL;
      8'(OFS_DMASTAT): f_decode = SEL_DMASTAT;
      default:         f_decode = SEL_NONE;
    endcase
  endfunction

  // clear first, then set: a set always wins
  function automatic word_t f_set_over_clr(input word_t cur, input word_t setv, input word_t clrv);
    f_set_over_clr = (cur & ~clrv) | setv;
  endfunction

  function automatic logic f_gate_irq(input word_t pend, input logic en);
    f_gate_irq = en & (|pend);
  endfunction

endpackage

// File: rtl/sdh_ctrl_reg.sv
`timescale 1ns/1ps
module sdh_ctrl_reg
  import sdh_irq_pkg::*;
#(
  parameter int DW   = WORD_W,
  parameter int NREQ = N_RST_REQ
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] ctrl_o,
  output logic [NREQ-1:0] req_pulse_o
);
  localparam logic [DW-1:0] REQ_MASK = DW'((64'd1 << NREQ) - 64'd1);

  logic [DW-1:0] ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ctrl_q <= DW'(CTRL_RST_VAL);
    else if (wr_i) ctrl_q <= wdata_i & ~REQ_MASK;
  end

  for (genvar g = 0; g < NREQ; g++) begin : g_req
    logic pulse_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse_q <= 1'b0;
      else        pulse_q <= wr_i & wdata_i[g];
    end
    assign req_pulse_o[g] = pulse_q;
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/sdh_card_track.sv
`timescale 1ns/1ps
module sdh_card_track
  import sdh_irq_pkg::*;
#(
  parameter int DW = WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ins_i,
  input  logic          rem_i,
  input  logic          present_clr_i,
  output logic [DW-1:0] set_vec_o,
  output logic [DW-1:0] clr_vec_o,
  output logic          present_o
);
  logic ins_eff;
  logic present_q;

  // removal takes priority when both pulses coincide
  assign ins_eff = ins_i & ~rem_i;

  always_comb begin
    set_vec_o = '0;
    clr_vec_o = '0;
    set_vec_o[BIT_CARD_IN]  = ins_eff;
    set_vec_o[BIT_CARD_OUT] = rem_i;
    clr_vec_o[BIT_CARD_IN]  = rem_i;
    clr_vec_o[BIT_CARD_OUT] = ins_eff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             present_q <= PRESENT_RST;
    else if (rem_i)         present_q <= 1'b0;
    else if (ins_eff)       present_q <= 1'b1;
    else if (present_clr_i) present_q <= 1'b0;
  end

  assign present_o = present_q;
endmodule

// File: rtl/sdh_raw_status.sv
`timescale 1ns/1ps
module sdh_raw_status
  import sdh_irq_pkg::*;
#(
  parameter int DW = WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mask_wr_i,
  input  logic          clr_wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] hw_set_i,
  input  logic [DW-1:0] hw_clr_i,
  input  logic          int_en_i,
  output logic [DW-1:0] raw_o,
  output logic [DW-1:0] mask_o,
  output logic [DW-1:0] pend_o,
  output logic          irq_o
);
  logic [DW-1:0] raw_q, mask_q, sw_clr, raw_d;

  assign sw_clr = clr_wr_i ? wdata_i : '0;
  assign raw_d  = f_set_over_clr(raw_q, hw_set_i, sw_clr | hw_clr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q <= raw_d;
      if (mask_wr_i) mask_q <= wdata_i;
    end
  end

  assign raw_o  = raw_q;
  assign mask_o = mask_q;
  assign pend_o = raw_q & mask_q;
  assign irq_o  = f_gate_irq(raw_q & mask_q, int_en_i);
endmodule

// File: rtl/sdh_dma_status.sv
`timescale 1ns/1ps
module sdh_dma_status
  import sdh_irq_pkg::*;
#(
  parameter int DW   = WORD_W,
  parameter int CLRW = DMA_CLR_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tx_i,
  input  logic            rx_i,
  input  logic            ctl_wr_i,
  input  logic [DW-1:0]   ctl_wdata_i,
  input  logic            stat_wr_i,
  input  logic [CLRW-1:0] stat_clr_i,
  output logic [DW-1:0]   ctl_o,
  output logic [DW-1:0]   stat_o
);
  logic [DW-1:0]   ctl_q;
  logic [CLRW-1:0] stat_q, setv, clrv;

  always_comb begin
    setv = '0;
    setv[BIT_DMA_TX]  = tx_i;
    setv[BIT_DMA_RX]  = rx_i;
    setv[BIT_DMA_SUM] = tx_i | rx_i;
  end

  assign clrv = stat_wr_i ? stat_clr_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      stat_q <= '0;
    end else begin
      stat_q <= (stat_q & ~clrv) | setv;
      if (ctl_wr_i) ctl_q <= ctl_wdata_i;
    end
  end

  assign ctl_o  = ctl_q;
  assign stat_o = DW'(stat_q);
endmodule

// File: rtl/sdh_irq_status_unit.sv
`timescale 1ns/1ps
module sdh_irq_status_unit
  import sdh_irq_pkg::*;
#(
  parameter int DW = WORD_W,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr_i,
  input  logic          reg_wr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic [DW-1:0] ev_set_i,
  input  logic          card_ins_i,
  input  logic          card_rem_i,
  input  logic          dma_tx_done_i,
  input  logic          dma_rx_done_i,
  output logic          irq_o,
  output logic          soft_rst_o,
  output logic          fifo_rst_o,
  output logic          dma_rst_o
);
  reg_sel_e sel;
  logic w_ctrl_wr, w_mask_wr, w_raw_clr_wr, w_card_wr, w_dmactl_wr, w_dmastat_wr;
  logic [DW-1:0] w_ctrl, w_raw, w_mask, w_pend, w_dma_ctl, w_dma_stat;
  logic [DW-1:0] w_card_set, w_card_clr, w_hw_set, w_card_word;
  logic [N_RST_REQ-1:0] w_req;
  logic w_int_en, w_present;

  assign sel          = f_decode(8'(reg_addr_i));
  assign w_ctrl_wr    = reg_wr_i && (sel == SEL_CTRL);
  assign w_mask_wr    = reg_wr_i && (sel == SEL_MASK);
  assign w_raw_clr_wr = reg_wr_i && ((sel == SEL_PEND) || (sel == SEL_RAW));
  assign w_card_wr    = reg_wr_i && (sel == SEL_CARD);
  assign w_dmactl_wr  = reg_wr_i && (sel == SEL_DMACTL);
  assign w_dmastat_wr = reg_wr_i && (sel == SEL_DMASTAT);

  sdh_ctrl_reg #(.DW(DW), .NREQ(N_RST_REQ)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_i(w_ctrl_wr), .wdata_i(reg_wdata_i),
    .ctrl_o(w_ctrl), .req_pulse_o(w_req)
  );

  assign w_int_en   = w_ctrl[BIT_INT_EN];
  assign soft_rst_o = w_req[0];
  assign fifo_rst_o = w_req[1];
  assign dma_rst_o  = w_req[2];

  sdh_card_track #(.DW(DW)) u_card (
    .clk(clk), .rst_n(rst_n), .ins_i(card_ins_i), .rem_i(card_rem_i),
    .present_clr_i(w_card_wr & reg_wdata_i[BIT_PRESENT]),
    .set_vec_o(w_card_set), .clr_vec_o(w_card_clr), .present_o(w_present)
  );

  // card bits are owned by the card tracker only
  assign w_hw_set = (ev_set_i & ~DW'(CARD_MASK)) | w_card_set;

  sdh_raw_status #(.DW(DW)) u_raw (
    .clk(clk), .rst_n(rst_n), .mask_wr_i(w_mask_wr), .clr_wr_i(w_raw_clr_wr),
    .wdata_i(reg_wdata_i), .hw_set_i(w_hw_set), .hw_clr_i(w_card_clr),
    .int_en_i(w_int_en), .raw_o(w_raw), .mask_o(w_mask), .pend_o(w_pend),
    .irq_o(irq_o)
  );

  sdh_dma_status #(.DW(DW), .CLRW(DMA_CLR_W)) u_dma (
    .clk(clk), .rst_n(rst_n), .tx_i(dma_tx_done_i), .rx_i(dma_rx_done_i),
    .ctl_wr_i(w_dmactl_wr), .ctl_wdata_i(reg_wdata_i),
    .stat_wr_i(w_dmastat_wr), .stat_clr_i(reg_wdata_i[DMA_CLR_W-1:0]),
    .ctl_o(w_dma_ctl), .stat_o(w_dma_stat)
  );

  assign w_card_word = DW'(w_present) << BIT_PRESENT;

  always_comb begin
    case (sel)
      SEL_CTRL:    reg_rdata_o = w_ctrl;
      SEL_MASK:    reg_rdata_o = w_mask;
      SEL_PEND:    reg_rdata_o = w_pend;
      SEL_RAW:     reg_rdata_o = w_raw;
      SEL_CARD:    reg_rdata_o = w_card_word;
      SEL_DMACTL:  reg_rdata_o = w_dma_ctl;
      SEL_DMASTAT: reg_rdata_o = w_dma_stat;
      default:     reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/sdh_irq_chk.sv
`timescale 1ns/1ps
module sdh_irq_chk
  import sdh_irq_pkg::*;
#(
  parameter int DW = WORD_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq_o,
  input logic          int_en,
  input logic [DW-1:0] raw_q,
  input logic [DW-1:0] mask_q,
  input logic          present,
  input logic [DW-1:0] ev_set_i,
  input logic          card_ins_i,
  input logic          card_rem_i,
  input logic          dma_tx_done_i,
  input logic [DW-1:0] dma_stat,
  input logic          soft_rst_o,
  input logic          ctrl_wr,
  input logic          wdata_b0
);
  logic [DW-1:0] ev_plain;
  assign ev_plain = ev_set_i & ~DW'(CARD_MASK);

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !int_en |-> !irq_o); // R3
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((raw_q & mask_q) != '0)); // R3
  AST_CARD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(raw_q[BIT_CARD_IN] && raw_q[BIT_CARD_OUT])); // R6
  AST_INSERT_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    (card_ins_i && !card_rem_i) |=> (present && raw_q[BIT_CARD_IN])); // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_plain != '0) |=> ((raw_q & $past(ev_plain)) == $past(ev_plain))); // R5
  AST_DMA_TX_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    dma_tx_done_i |=> (dma_stat[BIT_DMA_TX] && dma_stat[BIT_DMA_SUM])); // R8
  AST_SOFT_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |-> $past(ctrl_wr && wdata_b0)); // R9
endmodule

bind sdh_irq_status_unit sdh_irq_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .int_en(w_int_en),
  .raw_q(w_raw), .mask_q(w_mask), .present(w_present), .ev_set_i(ev_set_i),
  .card_ins_i(card_ins_i), .card_rem_i(card_rem_i),
  .dma_tx_done_i(dma_tx_done_i), .dma_stat(w_dma_stat),
  .soft_rst_o(soft_rst_o), .ctrl_wr(w_ctrl_wr), .wdata_b0(reg_wdata_i[0])
);

// File: tb/sim_sdh_irq_status_unit.sv
`timescale 1ns/1ps
module sim_sdh_irq_status_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] ev_set = '0;
  logic        card_ins = 1'b0, card_rem = 1'b0, dtx = 1'b0, drx = 1'b0;
  logic        irq, srst, frst, drst;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  sdh_irq_status_unit u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr_i(reg_addr), .reg_wr_i(reg_wr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .ev_set_i(ev_set),
    .card_ins_i(card_ins), .card_rem_i(card_rem), .dma_tx_done_i(dtx),
    .dma_rx_done_i(drx), .irq_o(irq), .soft_rst_o(srst), .fifo_rst_o(frst),
    .dma_rst_o(drst)
  );

  // table entry: {is_event, addr[2:0], data[31:0], exp_raw[31:0], exp_irq}
  localparam logic [68:0] TBL [9] = '{
    {1'b1, 3'd0, 32'h0000_0004, 32'h0000_0004, 1'b1},
    {1'b1, 3'd0, 32'h0001_0000, 32'h0001_0004, 1'b1},
    {1'b0, 3'd3, 32'h0000_0004, 32'h0001_0000, 1'b0},
    {1'b1, 3'd0, 32'h0000_0008, 32'h0001_0008, 1'b1},
    {1'b0, 3'd2, 32'h0000_0008, 32'h0001_0000, 1'b0},
    {1'b1, 3'd0, 32'hC000_0001, 32'h0001_0001, 1'b0},
    {1'b0, 3'd3, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0},
    {1'b0, 3'd1, 32'h0000_0001, 32'h0000_0000, 1'b0},
    {1'b1, 3'd0, 32'h0000_0001, 32'h0000_0001, 1'b1}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    logic [31:0] v;
    logic [31:0] mask;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd(0, v); chk("R1 ctrl", v, 32'h300);
    rd(1, v); chk("R1 mask", v, 0);
    rd(2, v); chk("R1 pend", v, 0);
    rd(3, v); chk("R1 raw", v, 0);
    rd(4, v); chk("R1 card", v, 32'h100);
    rd(5, v); chk("R1 dmactl", v, 0);
    rd(6, v); chk("R1 dmastat", v, 0);
    chk("R1 irq", 32'(irq), 0);

    // setup: interrupt enable, mask bits 2 and 3
    wr(0, 32'h310);
    wr(1, 32'h0000_000C);
    mask = 32'h0000_000C;
    rd(1, v); chk("R10 mask readback", v, mask);

    // table walk: R2 R3 R4 R5
    for (int i = 0; i < 9; i++) begin
      logic [68:0] e;
      e = TBL[i];
      if (e[68]) begin
        ev_set = e[64:33];
        tick();
        ev_set = '0;
      end else begin
        wr(6'(e[67:65]), e[64:33]);
        if (e[67:65] == 3'd1) mask = e[64:33];
      end
      rd(3, v); chk("R4/R5 raw", v, e[32:1]);
      rd(2, v); chk("R2 pend", v, e[32:1] & mask);
      chk("R3 irq", 32'(irq), 32'(e[0]));
    end

    // R3 gating by enable bit
    wr(0, 32'h300);
    chk("R3 irq gated off", 32'(irq), 0);
    rd(2, v); chk("R2 pend kept while gated", v, 32'h1);
    wr(0, 32'h310);
    chk("R3 irq regated on", 32'(irq), 1);

    // R5 set beats same-cycle clear
    ev_set = 32'h40; tick(); ev_set = '0;
    reg_addr = 3; reg_wr = 1'b1; reg_wdata = 32'h61; ev_set = 32'h20;
    tick();
    reg_wr = 1'b0; reg_wdata = '0; ev_set = '0;
    rd(3, v); chk("R5 set wins", v, 32'h20);
    wr(3, 32'hFFFF_FFFF);

    // R6 card events
    card_ins = 1'b1; tick(); card_ins = 1'b0;
    rd(3, v); chk("R6 insert raw", v, 32'h4000_0000);
    rd(4, v); chk("R6 insert present", v, 32'h100);
    card_rem = 1'b1; tick(); card_rem = 1'b0;
    rd(3, v); chk("R6 remove raw", v, 32'h8000_0000);
    rd(4, v); chk("R6 remove present", v, 0);
    card_ins = 1'b1; tick(); card_ins = 1'b0;
    card_ins = 1'b1; card_rem = 1'b1; tick(); card_ins = 1'b0; card_rem = 1'b0;
    rd(3, v); chk("R6 both -> removal raw", v, 32'h8000_0000);
    rd(4, v); chk("R6 both -> removal present", v, 0);
    reg_addr = 3; reg_wr = 1'b1; reg_wdata = 32'hC000_0000; card_ins = 1'b1;
    tick();
    reg_wr = 1'b0; reg_wdata = '0; card_ins = 1'b0;
    rd(3, v); chk("R6 insert beats clear", v, 32'h4000_0000);

    // R7 card status write-one-clear
    wr(4, 32'h100);
    rd(4, v); chk("R7 present cleared", v, 0);
    rd(3, v); chk("R7 raw untouched", v, 32'h4000_0000);
    reg_addr = 4; reg_wr = 1'b1; reg_wdata = 32'h100; card_ins = 1'b1;
    tick();
    reg_wr = 1'b0; reg_wdata = '0; card_ins = 1'b0;
    rd(4, v); chk("R7 insert keeps present", v, 32'h100);

    // R8 DMA status
    dtx = 1'b1; tick(); dtx = 1'b0;
    rd(6, v); chk("R8 tx sets 0 and 8", v, 32'h101);
    wr(6, 32'h100);
    rd(6, v); chk("R8 clear summary", v, 32'h001);
    drx = 1'b1; tick(); drx = 1'b0;
    rd(6, v); chk("R8 rx sets 1 and 8", v, 32'h103);
    wr(6, 32'hFFFF_FC00);
    rd(6, v); chk("R8 high bits no effect", v, 32'h103);
    wr(6, 32'h0000_03FF);
    rd(6, v); chk("R8 low clear", v, 0);

    // R9 reset request pulses
    wr(0, 32'h317);
    chk("R9 soft pulse", 32'(srst), 1);
    chk("R9 fifo pulse", 32'(frst), 1);
    chk("R9 dma pulse", 32'(drst), 1);
    rd(0, v); chk("R9 ctrl low bits zero", v, 32'h310);
    tick();
    chk("R9 pulses one cycle", {29'd0, srst, frst, drst}, 0);
    wr(0, 32'h312);
    chk("R9 only fifo", {29'd0, srst, frst, drst}, 32'h2);

    // R10 DMA control storage
    wr(5, 32'hA5A5_5A5A);
    rd(5, v); chk("R10 dmactl readback", v, 32'hA5A5_5A5A);

    summary();
  end
endmodule